// File: doc/BRIEF.md
# Serial Port Register Block with Combined Interrupt

This block is the software-visible face of a simple serial port. A processor reaches it over a 32-bit register bus that is addressed by word index. The block holds the port's control, FIFO-control, baud and one-millisecond reference registers. It reports transmit and receive state through two status words and a test word. It raises one level interrupt, built from status bits that are masked by control enables.

On the line side the receive path keeps a single character. A producer offers bytes with a strobe. The block takes a byte only while no character is held, and the `rx_ready` output tells the producer when to hold off. A separate strobe reports a line break, which the block stores as a special receive word.

On the transmit side, a write to the transmit-data word launches a one-cycle byte strobe. The transmit-ready state stays low until the consumer signals completion.

Reading the receive word hands the held character to software and frees the buffer. Writing control word 2 with its soft-reset bit at zero returns the whole block to its reset state.

Top module: `serial_regblock`

## Requirements
- R1: Word indices decode as: 0x00 receive data, 0x10 transmit data (reads 0), 0x20..0x23 control 1..4, 0x24 FIFO control, 0x25 status 1, 0x26 status 2, 0x29 baud increment (reads 0), 0x2A modulator, 0x2B baud count, 0x2C one-ms reference, 0x2D test word. Any other index reads 0 and ignores writes. Writes to the test word are ignored.
- R2: After reset, the registers read as follows: status 1 = 0x6040 (RTS-state bit 14, transmit-ready bit 13, receiver-idle bit 6); status 2 = 0x4028 (transmit-empty bit 14, carrier-input bit 5, transmit-complete bit 3); test word = 0x0060 (receive-empty bit 5, transmit-empty bit 6); control 1 = 0; control 2 = 0x0001; control 3 = 0x0700; control 4, FIFO control, modulator and one-ms = 0; baud count = 4; receive word = 0x4000 (error flag bit 14).
- R3: Control 1..4, FIFO control, modulator and one-ms keep only bits 15:0 of a written word, and they read back the same value.
- R4: A write to control 2 with bit 0 (soft reset) at 0 restores every register and flag to its R2 value and clears any transmit in flight. Control 2 then holds the written low 16 bits with bit 0 forced to 1.
- R5: A read of the receive word while a character is held returns the stored word with bit 15 (character-ready) set. In the same cycle it clears receive-ready (status 1 bit 9) and data-ready (status 2 bit 0) and sets receive-empty. A read with no character held returns the stored word with bit 15 clear and changes nothing.
- R6: A byte strobe is taken only while no character is held. Taking it stores the byte in bits 7:0 with the upper bits zero, sets receive-ready and data-ready, clears receive-empty, and drops `rx_ready`. A strobe that arrives while a character is held is ignored.
- R7: A break strobe is taken under the same condition as a byte strobe. It stores 0x5800 (break bit 11, frame-error bit 12, error bit 14) and sets break-detect, status 2 bit 2. If a break strobe and a byte strobe arrive together, the break wins.
- R8: Status words are write-one-to-clear. In status 2, the bits 15, 13, 12, 11, 10, 8, 7, 6, 4, 2 and 1 clear where a 1 is written. In status 1 only bits 15, 12, 11, 10, 8, 7, 5 and 4 are clearable. All other status bits ignore writes. A break-detect set in the same cycle as its clear stays set.
- R9: A transmit-data write is taken only when control 2 bit 2 (transmit enable) is 1 and no byte is in flight. It pulses `tx_strobe` for one cycle in the following cycle, with `tx_byte` = written bits 7:0. From the write until `tx_done` it clears transmit-ready (status 1 bit 13) and transmit-complete (status 2 bit 3).
- R10: `irq` is high when any of the following status bits is set together with its enable: transmit-ready and receive-ready, each enabled by the same bit of control 1 (bits 13 and 9); transmit-empty, enabled by control 1 bit 6; transmit-complete and data-ready, enabled by control 4 bits 3 and 0.
- R11: A write to the baud-increment index stores its low 16 bits into the baud count, which reads back at index 0x2B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_widx | input | 6 | Word index (byte offset shifted right by 2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, combinational |
| rx_strobe | input | 1 | Received byte is offered |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Buffer is free, a byte or break may be offered |
| brk_strobe | input | 1 | Line break detected |
| tx_strobe | output | 1 | One-cycle launch of a transmit byte |
| tx_byte | output | 8 | Byte being launched |
| tx_done | input | 1 | Launched byte has left the port |
| irq | output | 1 | Combined level interrupt |

## Verification
The bench builds the block with its defaults: a 16-bit stored register width and 8-bit characters. At these values every flag position and reset constant in the requirements can be observed at the ports. A behavioural model tracks the held character, the in-flight byte and every control word. The bench compares `irq`, `rx_ready`, `tx_strobe` and `tx_byte` against that model on every cycle. The stimulus covers the points where the cycles meet: strobes offered while a character is held, relaunch attempts during a transmit in flight, a break clear that coincides with a break, and a soft reset issued with state pending.

// File: rtl/serial_reg_pkg.sv
// serial_reg_pkg: word indices, flag positions and reset constants shared by
// the serial register block, its sub-units and its checker.
package serial_reg_pkg;
    localparam int WIDX_W = 6;

    localparam logic [WIDX_W-1:0] WI_RXD  = 6'h00;
    localparam logic [WIDX_W-1:0] WI_TXD  = 6'h10;
    localparam logic [WIDX_W-1:0] WI_CR1  = 6'h20;
    localparam logic [WIDX_W-1:0] WI_CR2  = 6'h21;
    localparam logic [WIDX_W-1:0] WI_CR3  = 6'h22;
    localparam logic [WIDX_W-1:0] WI_CR4  = 6'h23;
    localparam logic [WIDX_W-1:0] WI_FCR  = 6'h24;
    localparam logic [WIDX_W-1:0] WI_ST1  = 6'h25;
    localparam logic [WIDX_W-1:0] WI_ST2  = 6'h26;
    localparam logic [WIDX_W-1:0] WI_BINC = 6'h29;
    localparam logic [WIDX_W-1:0] WI_BMOD = 6'h2A;
    localparam logic [WIDX_W-1:0] WI_BCNT = 6'h2B;
    localparam logic [WIDX_W-1:0] WI_MS   = 6'h2C;
    localparam logic [WIDX_W-1:0] WI_TST  = 6'h2D;

    // status 1 / control 1 share these positions
    localparam int B_TXRDY   = 13;
    localparam int B_RXRDY   = 9;
    localparam int B_RTSST   = 14;
    localparam int B_RXIDLE  = 6;
    localparam int B_TXMTEN  = 6;   // control 1
    // status 2 / control 4 share these positions
    localparam int B_TXEMPTY = 14;
    localparam int B_CDIN    = 5;
    localparam int B_TXCMPL  = 3;
    localparam int B_BRKDET  = 2;
    localparam int B_DATRDY  = 0;
    // control 2
    localparam int B_SRSTN   = 0;
    localparam int B_TXENA   = 2;
    // test word
    localparam int B_TRXEMP  = 5;
    localparam int B_TTXEMP  = 6;
    // receive word
    localparam int B_CHRDY   = 15;

    localparam logic [15:0] RX_ERR_WORD = 16'h4000;
    localparam logic [15:0] RX_BRK_WORD = 16'h5800;
    localparam logic [15:0] CR3_RST     = 16'h0700;
    localparam logic [15:0] BCNT_RST    = 16'h0004;
endpackage

// File: rtl/serial_rx_hold.sv
// serial_rx_hold: single-character receive holding buffer.
// Assumes the producer offers a byte or break only while 'held' is low;
// strobes arriving while a character is held are dropped.
module serial_rx_hold
    import serial_reg_pkg::*;
#(
    parameter int BUF_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load_byte,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              load_brk,
    input  logic              consume,
    input  logic              brk_clr,
    output logic              held,
    output logic [BUF_W-1:0]  buf_q,
    output logic              brk_det
);
    logic take;
    assign take = !held && (load_byte || load_brk);

    // Buffer, held flag and break-detect update; break wins over a byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            held    <= 1'b0;
            buf_q   <= BUF_W'(RX_ERR_WORD);
            brk_det <= 1'b0;
        end else if (take) begin
            held  <= 1'b1;
            buf_q <= load_brk ? BUF_W'(RX_BRK_WORD) : BUF_W'(byte_in);
            if (load_brk)
                brk_det <= 1'b1;
            else if (brk_clr)
                brk_det <= 1'b0;
        end else begin
            if (held && consume)
                held <= 1'b0;
            if (brk_clr)
                brk_det <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_tx_launch.sv
// serial_tx_launch: launches one transmit byte and tracks it until done.
// Assumes 'done' refers to the byte in flight; it is ignored when idle.
module serial_tx_launch #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              launch_req,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              done,
    output logic              pending,
    output logic              strobe,
    output logic [BYTE_W-1:0] byte_q
);
    logic launch;
    assign launch = launch_req && !pending;

    // In-flight flag and one-cycle launch strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pending <= 1'b0;
            strobe  <= 1'b0;
            byte_q  <= '0;
        end else begin
            strobe <= launch;
            if (launch) begin
                pending <= 1'b1;
                byte_q  <= byte_in;
            end else if (done) begin
                pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/serial_irq_join.sv
// serial_irq_join: combines masked status bits into one level interrupt.
// Assumes status 1 and control 1 align the ready flags bit for bit, and
// control 4 aligns its enables with status 2.
module serial_irq_join
    import serial_reg_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic [REG_W-1:0] st1,
    input  logic [REG_W-1:0] st2,
    input  logic [REG_W-1:0] cr1,
    input  logic [REG_W-1:0] cr4,
    output logic             irq
);
    logic [REG_W-1:0] rdy_sel;
    logic [REG_W-1:0] st2_mask;

    // Build the enable masks for both status words.
    always_comb begin
        rdy_sel = '0;
        rdy_sel[B_TXRDY] = 1'b1;
        rdy_sel[B_RXRDY] = 1'b1;
        st2_mask = '0;
        st2_mask[B_TXEMPTY] = cr1[B_TXMTEN];
        st2_mask[B_TXCMPL]  = cr4[B_TXCMPL];
        st2_mask[B_DATRDY]  = cr4[B_DATRDY];
    end

    assign irq = (|(st1 & cr1 & rdy_sel)) || (|(st2 & st2_mask));
endmodule

// File: rtl/serial_regblock.sv
// serial_regblock: register file of a simple serial port with one-character
// receive buffer, transmit launch and combined interrupt.
// Assumes one access per cycle; read data is combinational and a receive
// read consumes the character at the clock edge ending the access.
module serial_regblock
    import serial_reg_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int REG_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [WIDX_W-1:0] bus_widx,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              rx_strobe,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              rx_ready,
    input  logic              brk_strobe,
    output logic              tx_strobe,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_done,
    output logic              irq
);
    logic [REG_W-1:0] ctrl1_q, ctrl2_q, ctrl3_q, ctrl4_q;
    logic [REG_W-1:0] fifo_q, ms_q, bmod_q, bcnt_q;
    logic [REG_W-1:0] wlow, st1, st2, tst, rd_reg, rx_buf;
    logic wr, rd, soft_rst, held, brk_det, tx_pend;

    assign wlow     = bus_wdata[REG_W-1:0];
    assign wr       = bus_en && bus_we;
    assign rd       = bus_en && !bus_we;
    assign soft_rst = wr && (bus_widx == WI_CR2) && !bus_wdata[B_SRSTN];

    serial_rx_hold #(.BUF_W(REG_W), .BYTE_W(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst),
        .load_byte(rx_strobe), .byte_in(rx_byte), .load_brk(brk_strobe),
        .consume(rd && (bus_widx == WI_RXD)),
        .brk_clr(wr && (bus_widx == WI_ST2) && bus_wdata[B_BRKDET]),
        .held(held), .buf_q(rx_buf), .brk_det(brk_det)
    );

    serial_tx_launch #(.BYTE_W(BYTE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst),
        .launch_req(wr && (bus_widx == WI_TXD) && ctrl2_q[B_TXENA]),
        .byte_in(bus_wdata[BYTE_W-1:0]), .done(tx_done),
        .pending(tx_pend), .strobe(tx_strobe), .byte_q(tx_byte)
    );

    // Control, FIFO, baud and one-ms registers, with soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ctrl1_q <= '0;
            ctrl2_q <= '0;
            ctrl2_q[B_SRSTN] <= 1'b1;
            ctrl3_q <= REG_W'(CR3_RST);
            ctrl4_q <= '0;
            fifo_q  <= '0;
            ms_q    <= '0;
            bmod_q  <= '0;
            bcnt_q  <= REG_W'(BCNT_RST);
            if (rst_n)
                ctrl2_q <= wlow | REG_W'(1 << B_SRSTN);
        end else if (wr) begin
            case (bus_widx)
                WI_CR1:  ctrl1_q <= wlow;
                WI_CR2:  ctrl2_q <= wlow;
                WI_CR3:  ctrl3_q <= wlow;
                WI_CR4:  ctrl4_q <= wlow;
                WI_FCR:  fifo_q  <= wlow;
                WI_BINC: bcnt_q  <= wlow;
                WI_BMOD: bmod_q  <= wlow;
                WI_MS:   ms_q    <= wlow;
                default: ;
            endcase
        end
    end

    // Assemble status and test words from live state.
    always_comb begin
        st1 = '0;
        st1[B_RTSST]  = 1'b1;
        st1[B_RXIDLE] = 1'b1;
        st1[B_TXRDY]  = !tx_pend;
        st1[B_RXRDY]  = held;
        st2 = '0;
        st2[B_TXEMPTY] = 1'b1;
        st2[B_CDIN]    = 1'b1;
        st2[B_TXCMPL]  = !tx_pend;
        st2[B_BRKDET]  = brk_det;
        st2[B_DATRDY]  = held;
        tst = '0;
        tst[B_TRXEMP] = !held;
        tst[B_TTXEMP] = 1'b1;
    end

    // Read multiplexer on the word index.
    always_comb begin
        rd_reg = '0;
        case (bus_widx)
            WI_RXD: begin
                rd_reg = rx_buf;
                rd_reg[B_CHRDY] = held;
            end
            WI_CR1:  rd_reg = ctrl1_q;
            WI_CR2:  rd_reg = ctrl2_q;
            WI_CR3:  rd_reg = ctrl3_q;
            WI_CR4:  rd_reg = ctrl4_q;
            WI_FCR:  rd_reg = fifo_q;
            WI_ST1:  rd_reg = st1;
            WI_ST2:  rd_reg = st2;
            WI_BMOD: rd_reg = bmod_q;
            WI_BCNT: rd_reg = bcnt_q;
            WI_MS:   rd_reg = ms_q;
            WI_TST:  rd_reg = tst;
            default: rd_reg = '0;
        endcase
    end

    assign bus_rdata = BUS_W'(rd_reg);
    assign rx_ready  = !held;

    serial_irq_join #(.REG_W(REG_W)) u_irq (
        .st1(st1), .st2(st2), .cr1(ctrl1_q), .cr4(ctrl4_q), .irq(irq)
    );
endmodule

// File: rtl/serial_regblock_chk.sv
// serial_regblock_chk: temporal checks on the serial register block,
// bound to every instance of the top module.
module serial_regblock_chk
    import serial_reg_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int REG_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [WIDX_W-1:0] bus_widx,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              rx_strobe,
    input logic              rx_ready,
    input logic              tx_strobe,
    input logic              irq,
    input logic [REG_W-1:0]  ctrl1_q,
    input logic              soft_rst
);
    // R6: a taken byte drops rx_ready on the next cycle
    assert_rx_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && rx_ready && !soft_rst) |=> !rx_ready);

    // R5: reading a held character frees the buffer
    assert_rx_consume_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_widx == WI_RXD && !rx_ready) |=> rx_ready);

    // R5: a held character reads with character-ready set
    assert_rx_chrdy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_widx == WI_RXD && !rx_ready) |-> bus_rdata[B_CHRDY]);

    // R9: launch strobe lasts one cycle
    assert_tx_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |=> !tx_strobe);

    // R10: enabled receive-ready raises the interrupt
    assert_irq_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl1_q[B_RXRDY] && !rx_ready) |-> irq);

    // R4: soft reset frees the buffer and cancels a launch
    assert_soft_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (rx_ready && !tx_strobe));
endmodule

bind serial_regblock serial_regblock_chk #(.BUS_W(BUS_W), .REG_W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_widx(bus_widx), .bus_rdata(bus_rdata), .rx_strobe(rx_strobe),
    .rx_ready(rx_ready), .tx_strobe(tx_strobe), .irq(irq),
    .ctrl1_q(ctrl1_q), .soft_rst(soft_rst)
);

// File: tb/serial_regblock_tb.sv
// serial_regblock_tb: behavioural model compared every clock, plus read checks.
module serial_regblock_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [5:0]  bus_widx = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_strobe = 1'b0, brk_strobe = 1'b0, tx_done = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_ready, tx_strobe, irq;
    logic [7:0]  tx_byte;

    int total = 0, bad = 0, cycles = 0;

    // model state
    int m_c1, m_c2, m_c3, m_c4, m_fcr, m_ms, m_mod, m_cnt;
    int m_buf;
    bit m_held, m_brk, m_pend, m_txv;
    int m_txb;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_regblock u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_widx(bus_widx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_strobe(rx_strobe), .rx_byte(rx_byte), .rx_ready(rx_ready),
        .brk_strobe(brk_strobe), .tx_strobe(tx_strobe), .tx_byte(tx_byte),
        .tx_done(tx_done), .irq(irq)
    );

    task automatic m_reset();
        m_c1 = 0; m_c2 = 1; m_c3 = 'h700; m_c4 = 0; m_fcr = 0; m_ms = 0;
        m_mod = 0; m_cnt = 4; m_buf = 'h4000; m_held = 0; m_brk = 0;
        m_pend = 0; m_txv = 0; m_txb = 0;
    endtask

    function automatic int m_st1();
        return 'h4040 | (m_pend ? 0 : 'h2000) | (m_held ? 'h200 : 0);
    endfunction
    function automatic int m_st2();
        return 'h4020 | (m_pend ? 0 : 'h8) | (m_brk ? 'h4 : 0) | (m_held ? 1 : 0);
    endfunction

    function automatic int m_read(input int idx);
        case (idx)
            'h00: return m_buf | (m_held ? 'h8000 : 0);
            'h20: return m_c1;
            'h21: return m_c2;
            'h22: return m_c3;
            'h23: return m_c4;
            'h24: return m_fcr;
            'h25: return m_st1();
            'h26: return m_st2();
            'h2A: return m_mod;
            'h2B: return m_cnt;
            'h2C: return m_ms;
            'h2D: return 'h40 | (m_held ? 0 : 'h20);
            default: return 0;
        endcase
    endfunction

    function automatic bit m_irq();
        int mask;
        mask = ((m_c1 & 'h40) != 0 ? 'h4000 : 0) | (m_c4 & 'h9);
        return ((m_st1() & m_c1 & 'h2200) != 0) || ((m_st2() & mask) != 0);
    endfunction

    // Reference model: advance one clock from the inputs present at the edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_reset();
        end else begin
            int w;
            bit wr, rd, h0, p0, setb;
            w  = int'(bus_wdata[15:0]);
            wr = bus_en && bus_we;
            rd = bus_en && !bus_we;
            h0 = m_held; p0 = m_pend;
            if (wr && bus_widx == 6'h21 && !bus_wdata[0]) begin
                m_reset();
                m_c2 = w | 1;
            end else begin
                m_txv = 0;
                if (wr && bus_widx == 6'h10 && (m_c2 & 4) != 0 && !p0) begin
                    m_pend = 1; m_txv = 1; m_txb = int'(bus_wdata[7:0]);
                end else if (tx_done) begin
                    m_pend = 0;
                end
                if (wr) begin
                    case (bus_widx)
                        6'h20: m_c1 = w;
                        6'h21: m_c2 = w;
                        6'h22: m_c3 = w;
                        6'h23: m_c4 = w;
                        6'h24: m_fcr = w;
                        6'h29: m_cnt = w;
                        6'h2A: m_mod = w;
                        6'h2C: m_ms = w;
                        default: ;
                    endcase
                end
                setb = 0;
                if (!h0 && (brk_strobe || rx_strobe)) begin
                    m_held = 1;
                    if (brk_strobe) begin
                        m_buf = 'h5800; m_brk = 1; setb = 1;
                    end else begin
                        m_buf = int'(rx_byte);
                    end
                end else if (h0 && rd && bus_widx == 6'h00) begin
                    m_held = 0;
                end
                if (!setb && wr && bus_widx == 6'h26 && bus_wdata[2]) m_brk = 0;
            end
        end
    end

    // Per-cycle comparison of the line-side outputs (R6, R9, R10).
    always @(negedge clk) begin
        if (rst_n) begin
            total++;
            if (irq !== m_irq()) begin
                bad++; $display("FAIL R10 irq actual=%0b expected=%0b", irq, m_irq());
            end
            if (rx_ready !== !m_held) begin
                bad++; $display("FAIL R6 rx_ready actual=%0b expected=%0b", rx_ready, !m_held);
            end
            if (tx_strobe !== m_txv || (m_txv && tx_byte !== 8'(m_txb))) begin
                bad++; $display("FAIL R9 tx actual=%0b/%h expected=%0b/%h",
                                tx_strobe, tx_byte, m_txv, 8'(m_txb));
            end
        end
    end

    task automatic idle_inputs();
        bus_en = 0; bus_we = 0; rx_strobe = 0; brk_strobe = 0; tx_done = 0;
    endtask

    task automatic wr_reg(input logic [5:0] idx, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_widx = idx; bus_wdata = d;
        @(posedge clk); #1 idle_inputs();
    endtask

    task automatic rd_reg(input logic [5:0] idx, input string tag);
        int exp;
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_widx = idx;
        #1;
        exp = m_read(int'(idx));
        total++;
        if (bus_rdata !== 32'(exp)) begin
            bad++;
            $display("FAIL %s idx=%h actual=%h expected=%h", tag, idx, bus_rdata, 32'(exp));
        end
        @(posedge clk); #1 idle_inputs();
    endtask

    task automatic rd_lit(input logic [5:0] idx, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_widx = idx;
        #1;
        total++;
        if (bus_rdata !== exp) begin
            bad++;
            $display("FAIL %s idx=%h actual=%h expected=%h", tag, idx, bus_rdata, exp);
        end
        @(posedge clk); #1 idle_inputs();
    endtask

    task automatic rx_put(input logic [7:0] b);
        @(negedge clk); rx_strobe = 1; rx_byte = b;
        @(posedge clk); #1 idle_inputs();
    endtask

    task automatic brk_put();
        @(negedge clk); brk_strobe = 1;
        @(posedge clk); #1 idle_inputs();
    endtask

    task automatic done_pulse();
        @(negedge clk); tx_done = 1;
        @(posedge clk); #1 idle_inputs();
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R2 reset values
        rd_lit(6'h25, 32'h6040, "R2 st1");
        rd_lit(6'h26, 32'h4028, "R2 st2");
        rd_lit(6'h2D, 32'h0060, "R2 test");
        rd_lit(6'h21, 32'h0001, "R2 cr2");
        rd_lit(6'h22, 32'h0700, "R2 cr3");
        rd_lit(6'h2B, 32'h0004, "R2 bcnt");
        rd_lit(6'h00, 32'h4000, "R2 rxd");
        rd_reg(6'h20, "R2 cr1");
        // R3 16-bit storage
        wr_reg(6'h22, 32'hABCD1234); rd_lit(6'h22, 32'h1234, "R3 cr3");
        wr_reg(6'h24, 32'hFFFF00A5); rd_reg(6'h24, "R3 fcr");
        wr_reg(6'h2A, 32'h00017777); rd_reg(6'h2A, "R3 mod");
        wr_reg(6'h2C, 32'h12345678); rd_reg(6'h2C, "R3 ms");
        // R11 baud increment
        wr_reg(6'h29, 32'h00000055);
        rd_lit(6'h29, 32'h0, "R11 binc");
        rd_lit(6'h2B, 32'h55, "R11 bcnt");
        // R1 unmapped and test-word writes
        wr_reg(6'h05, 32'hFFFFFFFF); rd_lit(6'h05, 32'h0, "R1 unmapped");
        wr_reg(6'h2D, 32'h0000FFFF); rd_lit(6'h2D, 32'h0060, "R1 test");
        rd_lit(6'h10, 32'h0, "R1 txd");
        // R9 transmit gated off
        wr_reg(6'h10, 32'h41); rd_lit(6'h25, 32'h6040, "R9 gated");
        wr_reg(6'h21, 32'h0005);
        wr_reg(6'h10, 32'h42);
        rd_lit(6'h25, 32'h4040, "R9 busy st1");
        rd_lit(6'h26, 32'h4020, "R9 busy st2");
        wr_reg(6'h10, 32'h43);          // ignored while in flight
        repeat (2) @(posedge clk);
        done_pulse();
        rd_lit(6'h25, 32'h6040, "R9 done");
        wr_reg(6'h10, 32'h44); done_pulse();
        // R6 / R5 receive
        rx_put(8'h37);
        rd_lit(6'h25, 32'h6240, "R6 st1");
        rd_lit(6'h2D, 32'h0040, "R6 test");
        rx_put(8'h99);                  // dropped
        rd_lit(6'h00, 32'h8037, "R5 consume");
        rd_lit(6'h00, 32'h0037, "R5 empty read");
        rd_lit(6'h26, 32'h4028, "R5 st2");
        // R7 break, R8 W1C
        brk_put();
        rd_lit(6'h26, 32'h402D, "R7 brkdet");
        rd_lit(6'h00, 32'hD800, "R7 word");
        wr_reg(6'h25, 32'hFFFF); rd_lit(6'h25, 32'h6040, "R8 st1");
        wr_reg(6'h26, 32'hFFFB); rd_lit(6'h26, 32'h402C, "R8 keep");
        wr_reg(6'h26, 32'h0004); rd_lit(6'h26, 32'h4028, "R8 clear");
        // R7 break beats byte; R8 clear coincident with set
        @(negedge clk);
        brk_strobe = 1; rx_strobe = 1; rx_byte = 8'h11;
        bus_en = 1; bus_we = 1; bus_widx = 6'h26; bus_wdata = 32'h4;
        @(posedge clk); #1 idle_inputs();
        rd_lit(6'h00, 32'hD800, "R7 priority");
        rd_reg(6'h26, "R8 set wins");
        wr_reg(6'h26, 32'h4);
        // R10 interrupt sources
        wr_reg(6'h20, 32'h0200); rx_put(8'h5A);
        rd_reg(6'h00, "R10 rx");
        wr_reg(6'h20, 32'h2000); wr_reg(6'h20, 32'h0040); wr_reg(6'h20, 32'h0);
        wr_reg(6'h23, 32'h0001); rx_put(8'h6B); rd_reg(6'h00, "R10 dr");
        wr_reg(6'h23, 32'h0008); wr_reg(6'h10, 32'h77);
        repeat (2) @(posedge clk);
        done_pulse(); wr_reg(6'h23, 32'h0);
        // R4 soft reset with state pending
        wr_reg(6'h20, 32'h0200); wr_reg(6'h10, 32'h55); rx_put(8'h12);
        wr_reg(6'h21, 32'h0004);
        rd_lit(6'h21, 32'h0005, "R4 cr2");
        rd_lit(6'h20, 32'h0000, "R4 cr1");
        rd_lit(6'h2B, 32'h0004, "R4 bcnt");
        rd_lit(6'h22, 32'h0700, "R4 cr3");
        rd_lit(6'h25, 32'h6040, "R4 st1");
        rd_lit(6'h00, 32'h4000, "R4 rxd");
        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule